// File: doc/BRIEF.md
# Floppy Head Stepping Controller

This block moves the read/write head of a single-density floppy drive with 77 tracks. A host asks for one of two jobs with a one-cycle strobe. A seek steps the head to a target track. A restore drives the head outward until the drive reports that it sits over track 0. The block produces the direction level and the active-low step pulses. It keeps a register holding the current track, and from that track it drives the output that selects the reduced write current.

While a job runs the block shows busy and ignores new strobes. When the job ends it gives a one-cycle done pulse. An error level goes with that pulse and stays valid until the next job is accepted. The track-0 sensor acts as a hard stop: the block never issues an outward step while that sensor is active. A restore also gives up after a bounded number of steps, so a drive that is not connected cannot hang it.

Top module: `fdd_stepper`

## Requirements
- R1: Tracks are numbered 0 to NUM_TRACKS-1 (0 to 76 by default). A seek whose target is above the last track is rejected. The block raises done together with the error level one cycle after the strobe, issues no step, and leaves the current track unchanged.
- R2: For a seek, the direction output is 1 (inward) when the target is above the current track and 0 (outward) when it is below. The block issues exactly |target − current| step pulses. It ends with the current track equal to the target and the error level low.
- R3: The direction output settles at least one clock cycle before a step pulse falls, and it holds its value until that pulse has risen again.
- R4: Each step pulse is low for exactly STEP_LOW_CYC cycles. Within a job, the output stays high for exactly STEP_GAP_CYC+1 cycles between two pulses.
- R5: No outward step is issued while the active-low track-0 input is low. If a seek sees that input low before an outward step, the seek ends with the error level high and the current track set to 0.
- R6: The outer-zone output is 1 while the current track is 0..43 and 0 while it is 44 or above.
- R7: A restore requested while the active-low ready input is high ends one cycle after the strobe with the error level high and no step issued.
- R8: A restore steps outward until the track-0 input is low. It then ends with the current track 0 and the error level low. A restore that starts over track 0 issues no step.
- R9: If the track-0 input is still high after RESTORE_LIMIT (default 80) outward steps, the restore ends with the error level high. It issues no further step and leaves the current track unchanged.
- R10: Strobes that arrive while busy is high are ignored. When the seek and restore strobes arrive in the same idle cycle, the restore is performed.
- R11: A seek to the track the head is already on ends one cycle after the strobe with no step and no error.
- R12: After reset the block is idle: busy low, done low, error low, current track 0, direction 0 and the step output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_seek_i | input | 1 | One-cycle strobe that starts a seek |
| cmd_restore_i | input | 1 | One-cycle strobe that starts a restore |
| cmd_target_i | input | TRK_W | Target track for a seek |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a job |
| seek_err_o | output | 1 | The last job failed; valid from done until the next accepted job |
| cur_track_o | output | TRK_W | Current track register |
| drv_dir_o | output | 1 | Step direction: 1 inward, 0 outward |
| drv_step_n_o | output | 1 | Step pulse, active low |
| drv_outer_zone_o | output | 1 | 1 for tracks 0..43 (full write current), 0 above |
| drv_trk0_n_i | input | 1 | Head over track 0, active low |
| drv_ready_n_i | input | 1 | Drive ready, active low |

## Verification
With P = STEP_LOW_CYC + STEP_GAP_CYC + 1, the done pulse is due at a fixed delay after the cycle in which the strobe is driven:
- a seek of n steps: n·P + 1 cycles;
- a rejected seek, a seek to the current track, or a restore refused because the drive is not ready: 1 cycle;
- a restore that reaches the sensor after k steps: k·P + 2 cycles;
- a seek stopped by the sensor before its first step: 2 cycles;
- a restore that exhausts its step budget: RESTORE_LIMIT·P + 2 cycles.

The driver puts each of these delays into the scoreboard item together with the expected error level, final track and step count. The monitor samples on the falling clock edge. It measures the delay between strobe and done with a free-running cycle counter, so an early or late done fails the check rather than being waited out. Pulse widths and gaps are measured the same way, between the sampled edges of the step output.

// File: rtl/fdd_step_pkg.sv
package fdd_step_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PREP = 2'd1,
        SQ_STEP = 2'd2
    } sq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_GAP  = 2'd2
    } pulse_phase_e;

    typedef enum logic {
        OP_SEEK    = 1'b0,
        OP_RESTORE = 1'b1
    } op_e;

    typedef struct packed {
        op_e  op;
        logic inward;
    } job_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fdd_step_pulser.sv
module fdd_step_pulser
    import fdd_step_pkg::*;
#(
    parameter int unsigned STEP_LOW_CYC = 4,
    parameter int unsigned STEP_GAP_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic step_n_o,
    output logic rise_o,
    output logic gap_end_o
);
    localparam int unsigned CNT_W = $clog2(max2(STEP_LOW_CYC, STEP_GAP_CYC) + 1);

    pulse_phase_e     ph_q;
    logic [CNT_W-1:0] cnt_q;

    assign rise_o    = (ph_q == PH_LOW) && (cnt_q == '0);
    assign gap_end_o = (ph_q == PH_GAP) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            cnt_q    <= '0;
            step_n_o <= 1'b1;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (fire_i) begin
                        ph_q     <= PH_LOW;
                        cnt_q    <= CNT_W'(STEP_LOW_CYC - 1);
                        step_n_o <= 1'b0;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == '0) begin
                        ph_q     <= PH_GAP;
                        cnt_q    <= CNT_W'(STEP_GAP_CYC - 1);
                        step_n_o <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt_q == '0) ph_q <= PH_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fdd_wcur_sel.sv
module fdd_wcur_sel #(
    parameter int unsigned TRK_W      = 7,
    parameter int unsigned OUTER_LAST = 43
) (
    input  logic [TRK_W-1:0] trk_i,
    output logic             outer_o
);
    assign outer_o = (trk_i <= TRK_W'(OUTER_LAST));
endmodule

// File: rtl/fdd_step_seq.sv
module fdd_step_seq
    import fdd_step_pkg::*;
#(
    parameter int unsigned TRK_W         = 7,
    parameter int unsigned MAX_TRK       = 76,
    parameter int unsigned RESTORE_LIMIT = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seek_i,
    input  logic             restore_i,
    input  logic [TRK_W-1:0] target_i,
    input  logic             trk0_n_i,
    input  logic             ready_n_i,
    input  logic             rise_i,
    input  logic             gap_end_i,
    output logic             fire_o,
    output logic             dir_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [TRK_W-1:0] track_o
);
    localparam int unsigned NS_W = $clog2(RESTORE_LIMIT + 1);

    sq_state_e        st_q;
    job_t             job_q;
    logic [TRK_W-1:0] tgt_q;
    logic [TRK_W-1:0] trk_q;
    logic [NS_W-1:0]  nstep_q;
    logic             at_stop;
    logic             budget_out;
    logic             reached;

    assign at_stop    = !job_q.inward && !trk0_n_i;
    assign budget_out = (job_q.op == OP_RESTORE) && (nstep_q == NS_W'(RESTORE_LIMIT));
    assign reached    = (job_q.op == OP_SEEK) && (trk_q == tgt_q);
    assign fire_o     = (st_q == SQ_PREP) && !at_stop && !budget_out;
    assign dir_o      = job_q.inward;
    assign busy_o     = (st_q != SQ_IDLE);
    assign track_o    = trk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            job_q   <= '{op: OP_SEEK, inward: 1'b0};
            tgt_q   <= '0;
            trk_q   <= '0;
            nstep_q <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (st_q)
                SQ_IDLE: begin
                    if (restore_i) begin
                        err_o <= 1'b0;
                        if (ready_n_i) begin
                            done_o <= 1'b1;
                            err_o  <= 1'b1;
                        end else begin
                            st_q    <= SQ_PREP;
                            job_q   <= '{op: OP_RESTORE, inward: 1'b0};
                            nstep_q <= '0;
                        end
                    end else if (seek_i) begin
                        err_o <= 1'b0;
                        if (target_i > TRK_W'(MAX_TRK)) begin
                            done_o <= 1'b1;
                            err_o  <= 1'b1;
                        end else if (target_i == trk_q) begin
                            done_o <= 1'b1;
                        end else begin
                            st_q  <= SQ_PREP;
                            tgt_q <= target_i;
                            job_q <= '{op: OP_SEEK, inward: (target_i > trk_q)};
                        end
                    end
                end
                SQ_PREP: begin
                    if (at_stop) begin
                        st_q   <= SQ_IDLE;
                        done_o <= 1'b1;
                        err_o  <= (job_q.op == OP_SEEK);
                        trk_q  <= '0;
                    end else if (budget_out) begin
                        st_q   <= SQ_IDLE;
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                    end else begin
                        st_q <= SQ_STEP;
                    end
                end
                SQ_STEP: begin
                    if (rise_i) begin
                        if (job_q.op == OP_SEEK)
                            trk_q <= job_q.inward ? trk_q + 1'b1 : trk_q - 1'b1;
                        else
                            nstep_q <= nstep_q + 1'b1;
                    end
                    if (gap_end_i) begin
                        if (reached) begin
                            st_q   <= SQ_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            st_q <= SQ_PREP;
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fdd_stepper.sv
module fdd_stepper
    import fdd_step_pkg::*;
#(
    parameter int unsigned NUM_TRACKS    = 77,
    parameter int unsigned OUTER_LAST    = 43,
    parameter int unsigned STEP_LOW_CYC  = 4,
    parameter int unsigned STEP_GAP_CYC  = 6,
    parameter int unsigned RESTORE_LIMIT = 80,
    localparam int unsigned TRK_W        = $clog2(NUM_TRACKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_seek_i,
    input  logic             cmd_restore_i,
    input  logic [TRK_W-1:0] cmd_target_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             seek_err_o,
    output logic [TRK_W-1:0] cur_track_o,
    output logic             drv_dir_o,
    output logic             drv_step_n_o,
    output logic             drv_outer_zone_o,
    input  logic             drv_trk0_n_i,
    input  logic             drv_ready_n_i
);
    logic fire;
    logic rise;
    logic gap_end;

    fdd_step_seq #(
        .TRK_W        (TRK_W),
        .MAX_TRK      (NUM_TRACKS - 1),
        .RESTORE_LIMIT(RESTORE_LIMIT)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .seek_i   (cmd_seek_i),
        .restore_i(cmd_restore_i),
        .target_i (cmd_target_i),
        .trk0_n_i (drv_trk0_n_i),
        .ready_n_i(drv_ready_n_i),
        .rise_i   (rise),
        .gap_end_i(gap_end),
        .fire_o   (fire),
        .dir_o    (drv_dir_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .err_o    (seek_err_o),
        .track_o  (cur_track_o)
    );

    fdd_step_pulser #(
        .STEP_LOW_CYC(STEP_LOW_CYC),
        .STEP_GAP_CYC(STEP_GAP_CYC)
    ) u_pulser (
        .clk      (clk),
        .rst      (rst),
        .fire_i   (fire),
        .step_n_o (drv_step_n_o),
        .rise_o   (rise),
        .gap_end_o(gap_end)
    );

    fdd_wcur_sel #(
        .TRK_W     (TRK_W),
        .OUTER_LAST(OUTER_LAST)
    ) u_wcur (
        .trk_i  (cur_track_o),
        .outer_o(drv_outer_zone_o)
    );
endmodule

// File: rtl/fdd_stepper_chk.sv
module fdd_stepper_chk #(
    parameter int unsigned TRK_W   = 7,
    parameter int unsigned MAX_TRK = 76
) (
    input logic             clk,
    input logic             rst,
    input logic             step_n,
    input logic             dir,
    input logic             trk0_n,
    input logic             busy,
    input logic             done,
    input logic [TRK_W-1:0] track
);
    // R3: direction already settled in the cycle before a pulse falls
    p_dir_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(step_n) |-> $stable(dir));

    // R3: direction unchanged while the pulse stays low
    p_dir_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!step_n && $past(!step_n)) |-> $stable(dir));

    // R5: an outward pulse never starts while the sensor reported track 0
    p_no_out_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(step_n) && !dir) |-> $past(trk0_n));

    // R1: the track register never leaves the legal range
    p_track_range_r1: assert property (@(posedge clk) disable iff (rst)
        track <= TRK_W'(MAX_TRK));

    // R10: no pulse is active outside a job
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> step_n);

    // R2: done is a single-cycle pulse and comes with the block idle
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind fdd_stepper fdd_stepper_chk #(
    .TRK_W  (TRK_W),
    .MAX_TRK(NUM_TRACKS - 1)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .step_n(drv_step_n_o),
    .dir   (drv_dir_o),
    .trk0_n(drv_trk0_n_i),
    .busy  (busy_o),
    .done  (done_o),
    .track (cur_track_o)
);

// File: tb/tb_fdd_stepper.sv
module tb_fdd_stepper;
    localparam int NT = 77, SPLIT = 43, LOWC = 4, GAPC = 6, LIM = 80;
    localparam int P = LOWC + GAPC + 1;
    localparam int TW = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          seek = 1'b0, restore = 1'b0;
    logic [TW-1:0] target = '0;
    logic          ready_n = 1'b1;
    logic          trk0_n;
    logic          busy, done, err, dir, step_n, outer;
    logic [TW-1:0] track;

    fdd_stepper #(
        .NUM_TRACKS(NT), .OUTER_LAST(SPLIT), .STEP_LOW_CYC(LOWC),
        .STEP_GAP_CYC(GAPC), .RESTORE_LIMIT(LIM)
    ) dut (
        .clk(clk), .rst(rst), .cmd_seek_i(seek), .cmd_restore_i(restore),
        .cmd_target_i(target), .busy_o(busy), .done_o(done), .seek_err_o(err),
        .cur_track_o(track), .drv_dir_o(dir), .drv_step_n_o(step_n),
        .drv_outer_zone_o(outer), .drv_trk0_n_i(trk0_n), .drv_ready_n_i(ready_n)
    );

    // drive model
    int head = 5;
    bit fake_zero = 0, no_sensor = 0;
    assign trk0_n = !(fake_zero || (!no_sensor && head == 0));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    err;
        int    trk;
        int    steps;
        int    lat;
        int    dirv;
        string req;
    } exp_t;
    exp_t q[$];

    int total = 0, bad = 0;
    int pushed = 0, popped = 0;
    int t0 = 0, steps_seen = 0, fall_cyc = 0, rise_cyc = -1;
    logic fall_dir = 1'b0, prev_step = 1'b1;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_step && !step_n) begin
                steps_seen++;
                fall_dir = dir;
                if (rise_cyc >= 0) chk(cyc - rise_cyc == GAPC + 1, "R4", "gap", cyc - rise_cyc, GAPC + 1);
                fall_cyc = cyc;
                head = dir ? head + 1 : (head > 0 ? head - 1 : 0);
            end
            if (!prev_step && step_n) begin
                chk(dir == fall_dir, "R3", "dir changed in pulse", dir, fall_dir);
                chk(cyc - fall_cyc == LOWC, "R4", "pulse width", cyc - fall_cyc, LOWC);
                rise_cyc = cyc;
            end
            prev_step = step_n;
            if (done) begin
                if (q.size() == 0) begin
                    chk(0, "R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(int'(err) == e.err, e.req, "error", err, e.err);
                    chk(int'(track) == e.trk, e.req, "track", track, e.trk);
                    chk(steps_seen == e.steps, e.req, "steps", steps_seen, e.steps);
                    chk(cyc - t0 == e.lat, e.req, "latency", cyc - t0, e.lat);
                    chk(int'(outer) == (e.trk <= SPLIT ? 1 : 0), "R6", "outer zone", outer, e.trk <= SPLIT);
                    if (e.dirv >= 0) chk(int'(dir) == e.dirv, "R2", "direction", dir, e.dirv);
                    popped++;
                end
            end
        end
    end

    task automatic expect_item(int e_err, int e_trk, int e_steps, int e_lat, int e_dir, string req);
        exp_t e;
        e.err = e_err; e.trk = e_trk; e.steps = e_steps; e.lat = e_lat; e.dirv = e_dir; e.req = req;
        q.push_back(e);
        pushed++;
    endtask

    task automatic strobe(bit s, bit r, int tgt);
        @(negedge clk);
        steps_seen = 0;
        rise_cyc   = -1;
        target     = TW'(tgt);
        seek       = s;
        restore    = r;
        t0         = cyc;
        @(negedge clk);
        seek    = 1'b0;
        restore = 1'b0;
    endtask

    task automatic wait_done();
        while (popped < pushed) @(negedge clk);
    endtask

    task automatic issue(bit s, bit r, int tgt, int e_err, int e_trk, int e_steps,
                         int e_lat, int e_dir, string req);
        expect_item(e_err, e_trk, e_steps, e_lat, e_dir, req);
        strobe(s, r, tgt);
        wait_done();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(busy == 0, "R12", "busy", busy, 0);
        chk(done == 0 && err == 0, "R12", "done/err", {done, err}, 0);
        chk(track == 0, "R12", "track", track, 0);
        chk(step_n == 1 && dir == 0, "R12", "step/dir", {step_n, dir}, 2);

        issue(0, 1, 0, 1, 0, 0, 1, -1, "R7");              // not ready
        ready_n = 1'b0;
        issue(0, 1, 0, 0, 0, 5, 5 * P + 2, 0, "R8");       // head at 5
        issue(1, 0, 43, 0, 43, 43, 43 * P + 1, 1, "R2");
        issue(1, 0, 44, 0, 44, 1, P + 1, 1, "R6");
        issue(1, 0, 76, 0, 76, 32, 32 * P + 1, 1, "R2");
        issue(1, 0, 76, 0, 76, 0, 1, -1, "R11");
        issue(1, 0, 100, 1, 76, 0, 1, -1, "R1");
        issue(1, 0, 10, 0, 10, 66, 66 * P + 1, 0, "R2");
        fake_zero = 1;
        issue(1, 0, 3, 1, 0, 0, 2, -1, "R5");
        fake_zero = 0;
        issue(0, 1, 0, 0, 0, 10, 10 * P + 2, 0, "R8");     // head back from 10
        issue(1, 0, 20, 0, 20, 20, 20 * P + 1, 1, "R2");
        no_sensor = 1;
        issue(0, 1, 0, 1, 20, LIM, LIM * P + 2, 0, "R9");
        no_sensor = 0;
        issue(0, 1, 0, 0, 0, 0, 2, -1, "R8");              // head already at 0

        // R10: strobes during a job are ignored
        expect_item(0, 5, 5, 5 * P + 1, 1, "R10");
        strobe(1, 0, 5);
        repeat (10) @(negedge clk);
        seek = 1'b1; restore = 1'b1; target = TW'(60);
        @(negedge clk);
        seek = 1'b0; restore = 1'b0;
        wait_done();
        chk(head == 5, "R10", "head position", head, 5);

        // R10: restore wins when both strobes coincide
        issue(1, 1, 50, 0, 0, 5, 5 * P + 2, 0, "R10");

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R10", "pending items", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule